// File: doc/BRIEF.md
# Fast-Column DRAM Read Access Controller

This block is a clocked model of the column-access control in a DRAM read path that runs in fast-column mode. The active-low row strobe opens a row and captures the row address from a multiplexed address bus. While the row stays open, each falling edge of the active-low column strobe captures a column address and starts a read of a small internal storage array. The read data is presented after a column latency and no earlier than a longer row latency, both counted in clock cycles.

Unlike classic page mode, a started column cycle always runs to completion inside the block, even if the column strobe goes high early. A recovery period, timed internally, then follows. The data output stays driven across column-strobe rising edges and between successive reads. It is turned off only when the row closes or when a column edge arrives with write enable asserted. A column edge that lands inside a running access or recovery window is dropped, and a sticky violation flag records it.

Top module: `fcol_read_ctrl`

## Requirements
- R1: After reset, `dout_oe` is 0, `viol` is 0 and `dout` is 0.
- R2: A falling edge of `row_stb_n` captures the row address from `addr[ROW_W-1:0]`. The storage word at row r, column c reads as ((r*COLS + c)*29 + 90) mod 2^DATA_W, with COLS = 2^COL_W.
- R3: The column address is captured from `addr[COL_W-1:0]` at the clock edge that sees the column-strobe falling edge. Changes on `addr` after that edge do not change the data returned.
- R4: If the column edge is seen at clock edge k and the row is already ready, `dout` takes the new word at edge k+T_CAC and `dout_oe` is 1 from that edge on.
- R5: If the row edge was seen at clock edge r, the new word appears no earlier than edge r+T_RAC. The completion edge is therefore max(k+T_CAC, r+T_RAC).
- R6: While `row_stb_n` stays low, `dout_oe` stays 1 across column-strobe rising edges and between successive reads.
- R7: A started read completes with the captured column's data even when `col_stb_n` rises before the completion edge.
- R8: After completion at edge c, a recovery window lasts T_REC edges, so the next column edge is accepted at edge c+T_REC+1 or later. A column edge seen during the access or the recovery window is ignored, and it sets `viol`, which stays 1 until reset.
- R9: When `row_stb_n` is sampled high, the row closes and `dout_oe` is 0 after that edge. Column edges seen while the row is closed are ignored and do not set `viol`.
- R10: A column edge accepted with `wr_en_n` low drives `dout_oe` to 0 after that edge, leaves `dout` unchanged and starts no read.
- R11: Until a new read completes, `dout` holds the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_stb_n | input | 1 | Active-low row strobe; high means standby |
| col_stb_n | input | 1 | Active-low column strobe |
| wr_en_n | input | 1 | Active-low write enable, sampled at the column edge |
| addr | input | max(ROW_W,COL_W) | Multiplexed row/column address |
| dout | output | DATA_W | Read data |
| dout_oe | output | 1 | Output enable for the tri-state data driver |
| viol | output | 1 | Sticky flag for a column edge inside a busy window |

## Verification
The hardest case to reach from the ports is a column edge that falls inside the access window. To produce it, the strobe has to rise and fall again within T_CAC cycles while the address bus carries a different column. The bench drives this as a directed case and then checks two things: the earlier column's data still appears on schedule, and nothing changes afterwards. The random reads vary how long the strobe stays low, so early rises before completion and late rises after it both occur. They also vary the delay after the row opens, so that the row latency sometimes sets the completion edge.

// File: rtl/fcol_pkg.sv
// Package fcol_pkg: shared types and the storage fill pattern.
// Assumes: storage content is fixed at reset; no write datapath exists.
package fcol_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACC  = 2'd1,
        PH_REC  = 2'd2
    } col_phase_e;

    // Fill value of the word at (row, col) for a given row length.
    function automatic int fill_word(input int row, input int col, input int cols);
        return (row * cols + col) * 29 + 90;
    endfunction

endpackage

// File: rtl/fcol_strobe_sync.sv
// Module fcol_strobe_sync: keeps the previous level of both strobes and
// flags their falling edges on the clock edge that first sees them low.
// Assumes: strobes are already synchronous to clk.
module fcol_strobe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic row_stb_n,
    input  logic col_stb_n,
    output logic row_fall,
    output logic col_fall
);

    logic row_prev;
    logic col_prev;

    // Remember last sampled strobe levels (inactive high after reset).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_prev <= 1'b1;
            col_prev <= 1'b1;
        end else begin
            row_prev <= row_stb_n;
            col_prev <= col_stb_n;
        end
    end

    // Falling edge = was high, now low.
    always_comb begin
        row_fall = row_prev & ~row_stb_n;
        col_fall = col_prev & ~col_stb_n;
    end

endmodule

// File: rtl/fcol_store.sv
// Module fcol_store: small storage array of 2^ROW_W x 2^COL_W words, loaded
// with a computed pattern at reset, with one combinational read port.
// Assumes: read addresses are held stable by the caller while used.
module fcol_store
    import fcol_pkg::*;
#(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data
);

    localparam int ROWS = 1 << ROW_W;
    localparam int COLS = 1 << COL_W;

    logic [DATA_W-1:0] mem [ROWS][COLS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            // Load this cell with its pattern value at reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[r][c] <= DATA_W'(fill_word(r, c, COLS));
                end
            end
        end
    end

    // Combinational read of the addressed word.
    always_comb begin
        rd_data = mem[rd_row][rd_col];
    end

endmodule

// File: rtl/fcol_col_seq.sv
// Module fcol_col_seq: column-cycle sequencer. Counts column and row
// latency, runs an internal recovery window after each read, and rejects
// column edges that arrive while busy (sticky violation).
// Assumes: T_CAC >= 1, T_RAC >= 1, T_REC >= 1.
module fcol_col_seq
    import fcol_pkg::*;
#(
    parameter int T_CAC = 3,
    parameter int T_RAC = 6,
    parameter int T_REC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic row_idle,
    input  logic row_fall,
    input  logic col_edge,
    input  logic we_n,
    output logic col_accept,
    output logic we_cut,
    output logic done,
    output logic viol
);

    localparam int CW    = $clog2(T_CAC + 1);
    localparam int RW    = $clog2(T_RAC + 1);
    localparam int QW    = $clog2(T_REC + 1);
    localparam int AGE_W = $clog2(T_CAC + T_RAC + 2);
    localparam logic [CW-1:0]    CAC_V   = CW'(T_CAC);
    localparam logic [RW-1:0]    RAC_V   = RW'(T_RAC);
    localparam logic [QW-1:0]    REC_V   = QW'(T_REC);
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    col_phase_e        phase;
    logic [CW-1:0]     ccnt;
    logic [RW-1:0]     rcnt;
    logic [QW-1:0]     qcnt;
    logic [AGE_W-1:0]  acc_age;
    logic              busy;
    logic              collide;
    logic              start_rd;

    // Decode acceptance, collision and completion for this edge.
    always_comb begin
        busy       = (phase != PH_IDLE);
        col_accept = col_edge & ~busy;
        start_rd   = col_accept & we_n;
        we_cut     = col_accept & ~we_n;
        collide    = col_edge & busy;
        done       = (phase == PH_ACC) && !row_idle &&
                     (ccnt <= CW'(1)) && (rcnt == RAC_V);
    end

    // Row latency counter: edges since the row opened, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || row_idle) begin
            rcnt <= '0;
        end else if (row_fall) begin
            rcnt <= RW'(1);
        end else if (rcnt != RAC_V) begin
            rcnt <= rcnt + RW'(1);
        end
    end

    // Phase machine: idle -> access -> recovery -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n || row_idle) begin
            phase <= PH_IDLE;
            ccnt  <= '0;
            qcnt  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start_rd) begin
                        phase <= PH_ACC;
                        ccnt  <= CAC_V;
                    end
                end
                PH_ACC: begin
                    if (done) begin
                        phase <= PH_REC;
                        qcnt  <= REC_V;
                    end else if (ccnt > CW'(1)) begin
                        ccnt <= ccnt - CW'(1);
                    end
                end
                PH_REC: begin
                    if (qcnt <= QW'(1)) begin
                        phase <= PH_IDLE;
                    end else begin
                        qcnt <= qcnt - QW'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Sticky violation on any column edge during a busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol <= 1'b0;
        end else if (collide) begin
            viol <= 1'b1;
        end
    end

    // Age of the running access, kept for the latency check below.
    always_ff @(posedge clk) begin
        if (!rst_n || start_rd || phase != PH_ACC) begin
            acc_age <= '0;
        end else if (acc_age != AGE_MAX) begin
            acc_age <= acc_age + AGE_W'(1);
        end
    end

    assert_viol_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol);

    assert_busy_edge_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (col_edge && phase != PH_IDLE) |=> viol);

    assert_access_runs_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACC && !row_idle) |=> (phase != PH_IDLE));

    assert_no_early_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (acc_age >= AGE_W'(T_CAC - 1)));

endmodule

// File: rtl/fcol_read_ctrl.sv
// Module fcol_read_ctrl: top of the fast-column read controller. Opens a
// row on the row-strobe falling edge, captures column addresses on accepted
// column-strobe falling edges, and drives read data with an enable that
// survives column-strobe rising edges.
// Assumes: all inputs synchronous to clk; a column edge in the same clock as
// the row edge is not used.
module fcol_read_ctrl
    import fcol_pkg::*;
#(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8,
    parameter int T_CAC  = 3,
    parameter int T_RAC  = 6,
    parameter int T_REC  = 2,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_stb_n,
    input  logic              col_stb_n,
    input  logic              wr_en_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              viol
);

    logic              row_fall;
    logic              col_fall;
    logic              row_open;
    logic              col_edge;
    logic              col_accept;
    logic              we_cut;
    logic              done;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [DATA_W-1:0] rd_data;

    fcol_strobe_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_stb_n (row_stb_n),
        .col_stb_n (col_stb_n),
        .row_fall  (row_fall),
        .col_fall  (col_fall)
    );

    // Column edges only count when the row was already open and still is.
    always_comb begin
        col_edge = col_fall & row_open & ~row_stb_n;
    end

    fcol_col_seq #(
        .T_CAC (T_CAC),
        .T_RAC (T_RAC),
        .T_REC (T_REC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .row_idle   (row_stb_n),
        .row_fall   (row_fall),
        .col_edge   (col_edge),
        .we_n       (wr_en_n),
        .col_accept (col_accept),
        .we_cut     (we_cut),
        .done       (done),
        .viol       (viol)
    );

    fcol_store #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_row  (row_q),
        .rd_col  (col_q),
        .rd_data (rd_data)
    );

    // Row state and row address capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open <= 1'b0;
            row_q    <= '0;
        end else if (row_stb_n) begin
            row_open <= 1'b0;
        end else if (row_fall) begin
            row_open <= 1'b1;
            row_q    <= addr[ROW_W-1:0];
        end
    end

    // Column address capture on an accepted column edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
        end else if (col_accept) begin
            col_q <= addr[COL_W-1:0];
        end
    end

    // Data register: changes only when a read completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (done) begin
            dout <= rd_data;
        end
    end

    // Output enable: on at completion, off on standby or a write edge.
    always_ff @(posedge clk) begin
        if (!rst_n || row_stb_n || we_cut) begin
            dout_oe <= 1'b0;
        end else if (done) begin
            dout_oe <= 1'b1;
        end
    end

    assert_standby_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        row_stb_n |=> !dout_oe);

    assert_oe_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && !row_stb_n && !we_cut) |=> dout_oe);

    assert_data_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(dout));

    assert_col_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !col_accept |=> $stable(col_q));

    assert_write_edge_hiz_R10: assert property (@(posedge clk) disable iff (!rst_n)
        we_cut |=> !dout_oe);

endmodule

// File: tb/fcol_read_ctrl_tb_top.sv
`timescale 1ns/1ps
module fcol_read_ctrl_tb_top;

    localparam int ROW_W  = 3;
    localparam int COL_W  = 3;
    localparam int DATA_W = 8;
    localparam int T_CAC  = 3;
    localparam int T_RAC  = 6;
    localparam int T_REC  = 2;
    localparam int COLS   = 1 << COL_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       row_stb_n = 1'b1;
    logic       col_stb_n = 1'b1;
    logic       wr_en_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] dout;
    logic       dout_oe;
    logic       viol;

    int n_run = 0;
    int n_fail = 0;
    int edge_n = 0;
    int r_edge = 0;
    int row_cur = 0;
    int hold_d = 0;
    bit hold_oe = 0;
    bit viol_exp = 0;
    bit finished = 0;

    fcol_read_ctrl #(
        .ROW_W (ROW_W), .COL_W (COL_W), .DATA_W (DATA_W),
        .T_CAC (T_CAC), .T_RAC (T_RAC), .T_REC (T_REC)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .row_stb_n (row_stb_n),
        .col_stb_n (col_stb_n), .wr_en_n (wr_en_n), .addr (addr),
        .dout (dout), .dout_oe (dout_oe), .viol (viol)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) edge_n <= edge_n + 1;

    function automatic int word_at(input int r, input int c);
        return ((r * COLS + c) * 29 + 90) & 255;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edge_n);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Check all three outputs against the held expectations.
    task automatic chk_hold(input string req);
        chk(dout == 8'(hold_d), req, dout, hold_d);
        chk(dout_oe == hold_oe, req, dout_oe, hold_oe);
        chk(viol == viol_exp, req, viol, viol_exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; row_stb_n = 1'b1; col_stb_n = 1'b1; wr_en_n = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        hold_d = 0; hold_oe = 0; viol_exp = 0;
        chk_hold("R1");
    endtask

    task automatic open_row(input int row, input int wait_n);
        row_stb_n = 1'b0; addr = 3'(row);
        tick();
        r_edge = edge_n; row_cur = row;
        for (int i = 0; i < wait_n; i++) begin
            addr = 3'($urandom);
            tick();
            chk_hold("R2");
        end
    endtask

    // Ends a row, then shows column edges in standby are ignored.
    task automatic close_row();
        row_stb_n = 1'b1; col_stb_n = 1'b1;
        tick();
        hold_oe = 0;
        chk_hold("R9");
        col_stb_n = 1'b0; addr = 3'($urandom);
        tick();
        chk_hold("R9");
        col_stb_n = 1'b1;
        tick();
        chk_hold("R9");
    endtask

    // One read with the strobe low for low_n edges; addr scrambled after capture.
    task automatic col_read(input int col, input int low_n);
        int k; int c; int fin; int exp_w; int t;
        col_stb_n = 1'b0; wr_en_n = 1'b1; addr = 3'(col);
        k = edge_n + 1;
        c = max2(k + T_CAC, r_edge + T_RAC);
        fin = c + T_REC;
        exp_w = word_at(row_cur, col);
        t = 0;
        do begin
            tick();
            t++;
            addr = 3'($urandom);
            if (t == low_n) col_stb_n = 1'b1;
            if (edge_n < c) begin
                chk_hold("R11");
            end else begin
                chk(dout == 8'(exp_w), (low_n < c - k + 1) ? "R7" : "R4", dout, exp_w);
                chk(dout_oe == 1'b1, "R6", dout_oe, 1);
                chk(viol == viol_exp, "R8", viol, viol_exp);
            end
        end while (edge_n < fin);
        col_stb_n = 1'b1;
        hold_d = exp_w; hold_oe = 1;
    endtask

    // Column edge with write enable low: output off, data kept, no read.
    task automatic col_write(input int col);
        col_stb_n = 1'b0; wr_en_n = 1'b0; addr = 3'(col);
        tick();
        hold_oe = 0;
        chk_hold("R10");
        col_stb_n = 1'b1; wr_en_n = 1'b1;
        for (int i = 0; i < T_CAC + 1; i++) begin
            tick();
            chk_hold("R10");
        end
    endtask

    initial begin
        #(200000.0 * 5.0 / 2.0);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        tick();
        do_reset();

        // Directed: column edge right after row edge, row latency sets timing.
        open_row(5, 0);
        col_read(2, 1);          // R5: completes at r+T_RAC, strobe rose early
        col_read(7, 5);          // R6: strobe held past completion
        col_write(3);            // R10
        col_read(0, 2);
        close_row();             // R9

        // Directed: collision inside the access window.
        open_row(2, 6);
        begin
            int k; int exp_w;
            col_stb_n = 1'b0; addr = 3'd4;
            k = edge_n + 1;
            exp_w = word_at(2, 4);
            tick();
            col_stb_n = 1'b1; addr = 3'd1;
            tick();
            col_stb_n = 1'b0;
            tick();
            viol_exp = 1;
            chk(viol == 1'b1, "R8", viol, 1);
            col_stb_n = 1'b1;
            while (edge_n < k + T_CAC) tick();
            chk(dout == 8'(exp_w), "R8", dout, exp_w);
            hold_d = exp_w; hold_oe = 1;
            for (int i = 0; i < T_REC + 4; i++) begin
                tick();
                chk_hold("R8");
            end
        end
        // Collision during recovery.
        begin
            int k;
            col_stb_n = 1'b0; addr = 3'd6;
            k = edge_n + 1;
            while (edge_n < k + T_CAC) tick();
            col_stb_n = 1'b1;
            hold_d = word_at(2, 6);
            chk_hold("R4");
            col_stb_n = 1'b0; addr = 3'd3;
            tick();
            chk_hold("R8");
            col_stb_n = 1'b1;
            repeat (T_REC + 3) begin
                tick();
                chk_hold("R8");
            end
        end
        close_row();

        do_reset();

        // Random rows and reads.
        for (int it = 0; it < 40; it++) begin
            open_row(int'($urandom_range(7, 0)), int'($urandom_range(4, 0)));
            for (int j = 0; j < int'($urandom_range(5, 1)); j++) begin
                if ($urandom_range(5, 0) == 0)
                    col_write(int'($urandom_range(7, 0)));
                else
                    col_read(int'($urandom_range(7, 0)),
                             int'($urandom_range(T_CAC + T_REC - 1, 1)));
            end
            close_row();
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule